// File: doc/BRIEF.md
# Dual-Accumulator Dot Product Engine

This block computes the dot product of a coefficient vector and a data vector that sit in a synchronous memory. Each memory word holds two signed 16-bit elements. The element with the even index sits in the low halfword, and the element with the odd index sits in the high halfword. After a start pulse the engine issues one pair of reads per cycle, one from the coefficient pointer and one from the data pointer. Both pointers move forward by one word after every read.

The engine keeps two partial sums. Even-indexed products go into one accumulator and odd-indexed products go into the other. The load latency and the one-cycle multiplier stage are modelled explicitly. Once the read counter is exhausted and the pipeline has drained, the two partial sums are added. The low halfword of that total is written to a destination address in a single write cycle, and a done strobe is raised in the same cycle.

Top module: `dotp_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, rd_en, wr_en and done are all low.
- R2: A start pulse sampled while the engine is idle captures both base pointers, the destination address and a pair count equal to elem_count shifted right by one. busy is high from the next cycle.
- R3: A run with P = elem_count/2 > 0 asserts rd_en for exactly P consecutive cycles. In the k-th of those cycles (k from 0), coef_addr equals coef_base+k and data_addr equals data_base+k.
- R4: Bits 15:0 of each fetched word hold the even-indexed element and bits 31:16 hold the odd-indexed element. Each product pairs the coefficient and data elements from the same halfword position. The two products of a word go to separate accumulators.
- R5: Read data is sampled exactly LOAD_LAT cycles after the cycle in which rd_en was high. Data on the read ports in any other cycle has no effect on the result.
- R6: Products are signed 16x16 and accumulated modulo 2^32. The written wr_data equals bits 15:0 of the sum of the even and odd accumulators.
- R7: The result is written in one cycle with wr_en and done high and wr_addr equal to the captured destination. done is high for exactly one cycle, and busy is low on the cycle after done.
- R8: An elem_count of 0 or 1 issues no reads and writes the value 0 to the destination.
- R9: An odd elem_count behaves exactly like the next lower even count; its lowest bit is ignored.
- R10: A start pulse while busy is high is ignored. The running result, read addresses and read count are unchanged, and no new run begins after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| elem_count | input | CW | Number of elements N |
| coef_base | input | AW | Word address of the first coefficient pair |
| data_base | input | AW | Word address of the first data pair |
| dest_addr | input | AW | Destination address of the result |
| busy | output | 1 | High from accepted start through the write cycle |
| rd_en | output | 1 | Read request on both read ports |
| coef_addr | output | AW | Coefficient read address |
| data_addr | output | AW | Data read address |
| coef_word | input | 2*EW | Coefficient word, valid LOAD_LAT cycles after request |
| data_word | input | 2*EW | Data word, valid LOAD_LAT cycles after request |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | AW | Result write address |
| wr_data | output | EW | Low halfword of the combined sum |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume a memory that returns each requested word exactly LOAD_LAT cycles after the request, with no backpressure. The bench memory model is a fixed-depth address pipe that matches LOAD_LAT. Outside the landing cycle it drives a poison pattern on the read ports, so any sampling at the wrong time corrupts the result. The assertions also assume a pair count that fits the address space without wrapping into the destination. Every directed case keeps its vectors and destination in separate memory regions.

// File: rtl/dotp_engine.sv
module dotp_engine #(
  parameter int EW       = 16,
  parameter int AW       = 8,
  parameter int CW       = 16,
  parameter int LOAD_LAT = 4,
  parameter int ACCW     = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   elem_count,
  input  logic [AW-1:0]   coef_base,
  input  logic [AW-1:0]   data_base,
  input  logic [AW-1:0]   dest_addr,
  output logic            busy,
  output logic            rd_en,
  output logic [AW-1:0]   coef_addr,
  output logic [AW-1:0]   data_addr,
  input  logic [2*EW-1:0] coef_word,
  input  logic [2*EW-1:0] data_word,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [EW-1:0]   wr_data,
  output logic            done
);
  localparam int PW = 2 * EW;

  typedef enum logic [1:0] {IDLE, RUN, DRAIN, STORE} state_t;

  state_t               st;
  logic [CW-1:0]        pairs_left;
  logic [AW-1:0]        cptr, dptr, dst;
  logic [LOAD_LAT-1:0]  inflight;
  logic                 land;
  logic signed [PW-1:0] prod_e, prod_o;
  logic                 prod_v;
  logic [ACCW-1:0]      acc_e, acc_o, total;
  logic [CW-1:0]        req_pairs;
  logic                 accept;

  assign req_pairs = elem_count >> 1;
  assign accept    = (st == IDLE) && start;
  assign land      = inflight[LOAD_LAT-1];
  assign total     = acc_e + acc_o;

  assign busy      = (st != IDLE);
  assign rd_en     = (st == RUN);
  assign coef_addr = cptr;
  assign data_addr = dptr;
  assign wr_en     = (st == STORE);
  assign done      = (st == STORE);
  assign wr_addr   = dst;
  assign wr_data   = total[EW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      pairs_left <= '0;
      cptr       <= '0;
      dptr       <= '0;
      dst        <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          cptr       <= coef_base;
          dptr       <= data_base;
          dst        <= dest_addr;
          pairs_left <= req_pairs;
          st         <= (req_pairs == '0) ? DRAIN : RUN;
        end
        RUN: begin
          cptr       <= cptr + 1'b1;
          dptr       <= dptr + 1'b1;
          pairs_left <= pairs_left - 1'b1;
          if (pairs_left == CW'(1)) st <= DRAIN;
        end
        DRAIN: if (inflight == '0 && !prod_v) st <= STORE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= '0;
      prod_v   <= 1'b0;
      prod_e   <= '0;
      prod_o   <= '0;
    end else begin
      inflight <= (inflight << 1) | LOAD_LAT'(rd_en);
      prod_v   <= land;
      if (land) begin
        prod_e <= $signed(coef_word[EW-1:0])  * $signed(data_word[EW-1:0]);
        prod_o <= $signed(coef_word[PW-1:EW]) * $signed(data_word[PW-1:EW]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || accept) begin
      acc_e <= '0;
      acc_o <= '0;
    end else if (prod_v) begin
      acc_e <= acc_e + ACCW'(prod_e);
      acc_o <= acc_o + ACCW'(prod_o);
    end
  end
endmodule

module dotp_engine_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          rd_en,
  input logic [AW-1:0] coef_addr,
  input logic [AW-1:0] data_addr,
  input logic          wr_en,
  input logic          done
);
  // R3
  rd_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);
  // R3
  coef_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> coef_addr == $past(coef_addr) + 1'b1);
  // R3
  data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> data_addr == $past(data_addr) + 1'b1);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R7
  write_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (busy && !rd_en));
  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind dotp_engine dotp_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .rd_en(rd_en),
  .coef_addr(coef_addr), .data_addr(data_addr), .wr_en(wr_en), .done(done)
);

// File: tb/dotp_engine_test.sv
module dotp_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] elem_count = '0;
  logic [7:0]  coef_base = '0, data_base = '0, dest_addr = '0;
  logic        busy, rd_en, wr_en, done;
  logic [7:0]  coef_addr, data_addr, wr_addr;
  logic [31:0] coef_word, data_word;
  logic [15:0] wr_data;

  int errors = 0;
  int checks = 0;

  logic [31:0] cmem [0:255];
  logic [31:0] dmem [0:255];
  logic [7:0]  cq [0:LAT-1];
  logic [7:0]  dq [0:LAT-1];
  logic        vq [0:LAT-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  dotp_engine #(.LOAD_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .elem_count(elem_count),
    .coef_base(coef_base), .data_base(data_base), .dest_addr(dest_addr),
    .busy(busy), .rd_en(rd_en), .coef_addr(coef_addr), .data_addr(data_addr),
    .coef_word(coef_word), .data_word(data_word), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  always @(posedge clk) begin
    cq[0] <= coef_addr;
    dq[0] <= data_addr;
    vq[0] <= rd_en;
    for (int i = 1; i < LAT; i++) begin
      cq[i] <= cq[i-1];
      dq[i] <= dq[i-1];
      vq[i] <= vq[i-1];
    end
  end

  // poison outside the landing cycle (R5)
  assign coef_word = (vq[LAT-1] === 1'b1) ? cmem[cq[LAT-1]] : 32'hDEAD_BEEF;
  assign data_word = (vq[LAT-1] === 1'b1) ? dmem[dq[LAT-1]] : 32'h5A5A_C3C3;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input int n, input logic [7:0] cb, input logic [7:0] db);
    logic [31:0] se, so;
    logic [31:0] pe, po;
    se = '0;
    so = '0;
    for (int k = 0; k < n / 2; k++) begin
      pe = 32'($signed(cmem[8'(cb + k)][15:0]) * $signed(dmem[8'(db + k)][15:0]));
      po = 32'($signed(cmem[8'(cb + k)][31:16]) * $signed(dmem[8'(db + k)][31:16]));
      se = se + pe;
      so = so + po;
    end
    return 16'(se + so);
  endfunction

  task automatic run_case(input int n, input logic [7:0] cb, input logic [7:0] db,
                          input logic [7:0] dst, input bit poke, input string tag);
    logic [15:0] exp;
    int reads;
    bit gap, got;
    exp = model(n, cb, db);
    reads = 0;
    gap = 0;
    got = 0;
    @(negedge clk);
    start = 1'b1;
    elem_count = 16'(n);
    coef_base = cb;
    data_base = db;
    dest_addr = dst;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {tag, " R2 busy after start"}, busy, 1);
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (poke && cyc == 2) begin
        start = 1'b1;
        elem_count = 16'd20;
        coef_base = 8'h00;
        data_base = 8'h00;
        dest_addr = 8'h11;
      end
      if (poke && cyc == 3) start = 1'b0;
      if (rd_en === 1'b1) begin
        if (coef_addr !== 8'(cb + reads) || data_addr !== 8'(db + reads) || gap) begin
          chk(0, {tag, " R3 read address/contiguity"}, {coef_addr, data_addr},
              {8'(cb + reads), 8'(db + reads)});
        end
        reads++;
      end else if (reads > 0) begin
        gap = 1;
      end
      if (done === 1'b1) begin
        got = 1;
        chk(wr_en === 1'b1 && wr_addr === dst, {tag, " R7 write strobe/address"},
            {wr_en, wr_addr}, {1'b1, dst});
        chk(wr_data === exp, {tag, " R4 R5 R6 result"}, wr_data, exp);
        break;
      end
      @(negedge clk);
    end
    chk(got, {tag, " R7 done seen"}, got, 1);
    chk(reads == n / 2, {tag, " R3 read count"}, reads, n / 2);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {tag, " R7 single pulse then idle"},
        {done, busy}, 0);
    if (poke) begin
      for (int i = 0; i < 4; i++) begin
        chk(busy === 1'b0 && rd_en === 1'b0, {tag, " R10 no run from ignored start"},
            {busy, rd_en}, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, rd_en, wr_en, done} === 4'b0, "R1 outputs in reset", {busy, rd_en, wr_en, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, rd_en, wr_en, done} === 4'b0, "R1 outputs after reset", {busy, rd_en, wr_en, done}, 0);
  endtask

  task automatic t_basic();
    run_case(8, 8'h10, 8'h40, 8'hF0, 0, "basic8");
    run_case(40, 8'h20, 8'h60, 8'hF1, 0, "long40");
    run_case(2, 8'h05, 8'h07, 8'hF2, 0, "single_pair");
  endtask

  task automatic t_big();
    for (int i = 0; i < 6; i++) begin
      cmem[8'hA0 + i] = (i % 2 == 0) ? 32'h8000_7FFF : 32'h8000_8000;
      dmem[8'hB0 + i] = (i % 3 == 0) ? 32'h8000_8000 : 32'h7FFF_8001;
    end
    run_case(12, 8'hA0, 8'hB0, 8'hF3, 0, "R6 wrap_large");
  endtask

  task automatic t_zero();
    run_case(0, 8'h10, 8'h40, 8'hF4, 0, "R8 n0");
    run_case(1, 8'h10, 8'h40, 8'hF5, 0, "R8 n1");
  endtask

  task automatic t_odd();
    run_case(7, 8'h30, 8'h70, 8'hF6, 0, "R9 odd7");
  endtask

  task automatic t_busy_start();
    run_case(10, 8'h12, 8'h52, 8'hF7, 1, "R10 start_while_busy");
  endtask

  task automatic t_addr_wrap();
    run_case(8, 8'hFE, 8'h80, 8'hF8, 0, "R3 ptr_wrap");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      cmem[i] = {16'(i * 977 - 3000), 16'(i * 313 + 17)};
      dmem[i] = {16'(40000 - i * 1231), 16'((i * 2111) ^ 16'h8A5C)};
    end
    t_reset();
    t_basic();
    t_big();
    t_zero();
    t_odd();
    t_busy_start();
    t_addr_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule